// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is an I2C bus master that software steers one byte at a time. Each command word that software writes can ask for a START condition, a STOP condition, the acknowledge behaviour for the ninth clock, and one byte. The block then runs that byte on the open-drain SCL and SDA lines. It makes one interrupt pulse when the byte ends and leaves the outcome in a result register: the sampled byte, the level seen in the acknowledge slot, and whether arbitration was lost. There is no busy or done flag to poll, so the interrupt is the only completion signal.

Software first programs two SCL timing counts and then sets the run and drive-enable bits in the control register. A write starts with a START command that carries the 7-bit address shifted left by one, with bit 0 as the read flag. Data bytes follow, and a STOP command ends the transfer. A write followed by a read can keep the bus by issuing a second START without a STOP in between. Between bytes the master holds SCL low, so the bus stays owned while software prepares the next command.

Register index (`reg_addr_i`): 0 = control, 1 = timing, 2 = command (reads as zero), 3 = result.

Top module: `i2c_byte_master`

## Requirements
- R1: Reset clears the control register. While control bit 0 (run) is 0 the engine is idle, produces no interrupt and ignores commands. The line enables `scl_oe_o` and `sda_oe_o` can only assert while control bit 1 (drive enable) is 1. With drive disabled, bytes still run and report their result.
- R2: The timing register holds the SCL half count in bits 31:16 and the full count in bits 15:0. Its reset value is 125/250. Each bit cell holds SCL low for the half count in cycles and releases it for the full count minus the half count. A legal setting has half ≥ 1 and half < full.
- R3: In a command word, bit 10 asks for START, bit 9 for STOP, bit 8 is the NACK control and bits 7:0 are the byte. A START makes SDA fall while SCL is high before the byte. A START issued while the bus is owned becomes a repeated START with no STOP before it.
- R4: A byte is sent most significant bit first over nine SCL cells. In data cells the master releases SDA for a 1 bit and pulls it low for a 0 bit. Bit 0 of the last START byte sets the direction: after a read address, the master releases SDA in all eight data cells. SDA does not change while SCL is high inside a byte.
- R5: In the acknowledge cell the master releases SDA when NACK is 1 and pulls it low when NACK is 0.
- R6: The result register holds the eight bits sampled on SCL rising edges in bits 7:0. Bit 11 holds the SDA level in the acknowledge cell (1 means not acknowledged), bit 9 flags lost arbitration, and bit 12 is 1 while the master owns the bus.
- R7: If the master releases SDA in a transmitted data cell and samples it low, it releases both lines in the next cycle. It then sets result bit 9, clears bit 12, raises the interrupt and does not generate a STOP.
- R8: A command with bit 9 set transfers no byte. It pulls SCL and SDA low, releases SCL and then SDA, raises the interrupt and clears result bit 12.
- R9: The interrupt is a one-cycle pulse. It fires once at the end of each acknowledge cell, once at the end of a STOP, and once on lost arbitration, and at no other time.
- R10: A command written while a START, byte or STOP is in progress is ignored. A command written in the cycle the interrupt is high is accepted.
- R11: After a byte, SCL stays pulled low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Completion pulse |
| scl_oe_o | output | 1 | Pulls SCL low when 1 |
| scl_i | input | 1 | Sampled SCL line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The completion pulse of one byte and the acceptance of the next command can fall in the same cycle. The bench provokes this by writing a new command on the very half-cycle it first sees the interrupt high. It judges the outcome by requiring a second interrupt and a result that matches the second byte. The opposite case is also tested: a command written a few cycles into a running byte must leave the result of the first byte unchanged and produce exactly one interrupt. A lost-arbitration sample at the same time as data shifting is covered by pulling SDA low in the third cell of a transmitted address.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CELLS  = BYTE_W + 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TIME = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_RES  = 2'd3;

  localparam int unsigned C_START = 10;
  localparam int unsigned C_STOP  = 9;
  localparam int unsigned C_NACK  = 8;

  localparam int unsigned R_OWN  = 12;
  localparam int unsigned R_ACK  = 11;
  localparam int unsigned R_LOST = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BYTE, ST_HOLD, ST_STOP
  } eng_st_e;

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              nack;
    logic [BYTE_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter logic [CW-1:0] HALF_RST = 125,
  parameter logic [CW-1:0] FULL_RST = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] result_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             run_o,
  output logic             drv_en_o,
  output logic [CW-1:0]    half_o,
  output logic [CW-1:0]    full_o,
  output logic             cmd_valid_o,
  output cmd_t             cmd_o
);
  logic run_q, drv_q;
  logic [CW-1:0] half_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      drv_q  <= 1'b0;
      half_q <= HALF_RST;
      full_q <= FULL_RST;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        run_q <= wdata_i[0];
        drv_q <= wdata_i[1];
      end
      if (addr_i == A_TIME) begin
        half_q <= wdata_i[2*CW-1:CW];
        full_q <= wdata_i[CW-1:0];
      end
    end
  end

  assign run_o       = run_q;
  assign drv_en_o    = drv_q;
  assign half_o      = half_q;
  assign full_o      = full_q;
  assign cmd_valid_o = we_i && (addr_i == A_CMD);
  assign cmd_o.start = wdata_i[C_START];
  assign cmd_o.stop  = wdata_i[C_STOP];
  assign cmd_o.nack  = wdata_i[C_NACK];
  assign cmd_o.data  = wdata_i[BYTE_W-1:0];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[1:0] = {drv_q, run_q};
      A_TIME:  rdata_o[2*CW-1:0] = {half_q, full_q};
      A_RES:   rdata_o = result_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_sclgen.sv
module i2cm_sclgen #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] full_i,
  output logic          half_end_o,
  output logic          cell_end_o,
  output logic          sample_o,
  output logic          high_o
);
  logic [CW-1:0] cnt_q;

  assign cell_end_o = cnt_q >= (full_i - CW'(1));
  assign half_end_o = cnt_q == (half_i - CW'(1));
  assign sample_o   = cnt_q == half_i;
  assign high_o     = cnt_q >= half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || cell_end_o) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          cmd_valid_i,
  input  cmd_t          cmd_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          half_end_i,
  input  logic          cell_end_i,
  input  logic          sample_i,
  input  logic          high_i,
  output logic          clr_o,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          irq_o,
  output logic [BW-1:0] rx_o,
  output logic          ack_o,
  output logic          lost_o,
  output logic          own_o
);
  localparam int unsigned BIT_W = $clog2(BW + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BW);

  eng_st_e st_q;
  logic [1:0] step_q;
  logic [BIT_W-1:0] bit_q;
  logic [BW-1:0] sh_q, rx_q;
  logic nack_q, rd_q, tx_q, own_q, ack_q, lost_q, irq_q;
  logic accept, lost_evt, smp;

  assign accept = run_i && cmd_valid_i &&
                  ((st_q == ST_HOLD) ||
                   (st_q == ST_IDLE && (cmd_i.start || cmd_i.stop)));
  assign smp = sample_i && scl_i;
  assign lost_evt = (st_q == ST_BYTE) && smp && (bit_q != LAST) &&
                    tx_q && sh_q[BW-1] && !sda_i;
  assign clr_o = accept ||
                 ((st_q == ST_START || st_q == ST_STOP) && half_end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; step_q <= '0; bit_q <= '0;
      sh_q <= '0; rx_q <= '0;
      nack_q <= 1'b1; rd_q <= 1'b0; tx_q <= 1'b1;
      own_q <= 1'b0; ack_q <= 1'b0; lost_q <= 1'b0; irq_q <= 1'b0;
    end else if (!run_i) begin
      st_q <= ST_IDLE; step_q <= '0; bit_q <= '0;
      own_q <= 1'b0; ack_q <= 1'b0; lost_q <= 1'b0; irq_q <= 1'b0;
      rx_q <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_HOLD: if (accept) begin
          lost_q <= 1'b0;
          nack_q <= cmd_i.nack;
          sh_q   <= cmd_i.data;
          step_q <= '0;
          bit_q  <= '0;
          if (cmd_i.stop) st_q <= ST_STOP;
          else if (cmd_i.start) begin
            st_q <= ST_START;
            tx_q <= 1'b1;
            rd_q <= cmd_i.data[0];
          end else begin
            st_q <= ST_BYTE;
            tx_q <= !rd_q;
          end
        end
        ST_START: if (half_end_i) begin
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) begin
            st_q  <= ST_BYTE;
            own_q <= 1'b1;
          end
        end
        ST_BYTE: begin
          if (lost_evt) begin
            st_q   <= ST_IDLE;
            own_q  <= 1'b0;
            lost_q <= 1'b1;
            irq_q  <= 1'b1;
          end else begin
            if (smp) begin
              if (bit_q == LAST) ack_q <= sda_i;
              else rx_q <= {rx_q[BW-2:0], sda_i};
            end
            if (cell_end_i) begin
              if (bit_q == LAST) begin
                st_q  <= ST_HOLD;
                irq_q <= 1'b1;
              end else begin
                bit_q <= bit_q + BIT_W'(1);
                sh_q  <= {sh_q[BW-2:0], 1'b0};
              end
            end
          end
        end
        ST_STOP: if (half_end_i) begin
          step_q <= step_q + 2'd1;
          if (step_q == 2'd2) begin
            st_q  <= ST_IDLE;
            own_q <= 1'b0;
            irq_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // line drive: 1 = pull low
  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    unique case (st_q)
      ST_START: begin
        scl_low_o = (step_q == 2'd0) ? own_q : (step_q == 2'd3);
        sda_low_o = step_q[1];
      end
      ST_BYTE: begin
        scl_low_o = !high_i;
        sda_low_o = (bit_q == LAST) ? !nack_q : (tx_q && !sh_q[BW-1]);
      end
      ST_HOLD: begin
        scl_low_o = 1'b1;
        sda_low_o = !nack_q;
      end
      ST_STOP: begin
        scl_low_o = (step_q == 2'd0);
        sda_low_o = (step_q != 2'd2);
      end
      default: ;
    endcase
  end

  assign irq_o  = irq_q;
  assign rx_o   = rx_q;
  assign ack_o  = ack_q;
  assign lost_o = lost_q;
  assign own_o  = own_q;

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (st_q inside {ST_START, ST_BYTE, ST_STOP}))
      |=> ($stable(nack_q) && $stable(rd_q)));

  // R4
  sda_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BYTE && $past(st_q) == ST_BYTE && !scl_low_o && !$past(scl_low_o))
      |-> (sda_low_o == $past(sda_low_o)));

  // R7
  lost_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_evt |=> (!scl_low_o && !sda_low_o && irq_o && lost_o && !own_o));

  // R1
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (st_q == ST_IDLE && !irq_o));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter logic [CW-1:0] HALF_RST = 125,
  parameter logic [CW-1:0] FULL_RST = 250
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        scl_oe_o,
  input  logic        scl_i,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  logic run, drv_en, cmd_valid, clr;
  logic half_end, cell_end, sample, high;
  logic scl_low, sda_low, ack, lost, own;
  logic [CW-1:0] half, full;
  logic [BYTE_W-1:0] rx;
  logic [REG_W-1:0] res_word;
  cmd_t cmd;

  i2cm_regs #(.CW(CW), .HALF_RST(HALF_RST), .FULL_RST(FULL_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .result_i(res_word), .rdata_o(reg_rdata_o),
    .run_o(run), .drv_en_o(drv_en), .half_o(half), .full_o(full),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd)
  );

  i2cm_sclgen #(.CW(CW)) u_sclgen (
    .clk_i, .rst_ni, .clr_i(clr), .half_i(half), .full_i(full),
    .half_end_o(half_end), .cell_end_o(cell_end),
    .sample_o(sample), .high_o(high)
  );

  i2cm_engine #(.BW(BYTE_W)) u_engine (
    .clk_i, .rst_ni, .run_i(run), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .scl_i, .sda_i,
    .half_end_i(half_end), .cell_end_i(cell_end),
    .sample_i(sample), .high_i(high),
    .clr_o(clr), .scl_low_o(scl_low), .sda_low_o(sda_low), .irq_o,
    .rx_o(rx), .ack_o(ack), .lost_o(lost), .own_o(own)
  );

  always_comb begin
    res_word = '0;
    res_word[BYTE_W-1:0] = rx;
    res_word[R_LOST] = lost;
    res_word[R_ACK]  = ack;
    res_word[R_OWN]  = own;
  end

  assign scl_oe_o = drv_en && scl_low;
  assign sda_oe_o = drv_en && sda_low;
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_pull);

  int n_chk = 0, n_fail = 0;
  logic [8:0] pat = '0;
  int rises = 0, starts = 0, stops = 0, irqs = 0, run_len = 0;
  int last_low = 0, last_high = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_irq = 1'b0;
  logic wide = 1'b0, oe_seen = 1'b0;

  always #10 clk = !clk;

  i2c_byte_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .scl_oe_o(scl_oe), .scl_i(scl_line), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // bus monitor and slave model: pat[8-k] pulls SDA in cell k
  always @(negedge clk) begin
    if (prev_scl && scl_line && prev_sda && !sda_line) begin starts++; rises = 0; end
    if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
    if (!prev_scl && scl_line) begin rises++; last_low = run_len; run_len = 1; end
    else if (prev_scl && !scl_line) begin
      last_high = run_len; run_len = 1;
      slv_pull = (rises < 9) ? pat[8-rises] : 1'b0;
    end else run_len++;
    if (irq) irqs++;
    if (irq && prev_irq) wide = 1'b1;
    if (scl_oe || sda_oe) oe_seen = 1'b1;
    prev_scl = scl_line; prev_sda = sda_line; prev_irq = irq;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cword(input logic s, input logic p, input logic n, input logic [7:0] d);
    return {21'd0, s, p, n, d};
  endfunction

  function automatic logic [31:0] expect_res(input logic tx, input logic [7:0] d,
                                             input logic n, input logic [8:0] p);
    logic [7:0] rx = '0;
    logic lost = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic rel;
      rel = tx ? d[7-k] : 1'b1;
      if (!lost) begin
        if (tx && rel && p[8-k]) lost = 1'b1;
        else rx = {rx[6:0], rel & !p[8-k]};
      end
    end
    if (lost) return 32'h0000_0200;
    return {19'd0, 1'b1, n & !p[0], 3'd0, rx};
  endfunction

  task automatic cmd(input logic s, input logic p, input logic n, input logic [7:0] d,
                     input logic [8:0] pt, input string tag);
    int cnt = 0;
    pat = pt;
    slv_pull = (s || p) ? 1'b0 : pt[8];
    rises = 0;
    wr(2'd2, cword(s, p, n, d));
    while (!irq && cnt < 2000) begin @(negedge clk); cnt++; end
    chk(irq, {tag, " irq"}, {31'd0, irq}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r, e;
    int c0;
    void'($urandom(32'h5EED_1C2A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk(r == 0, "R1 ctrl reset", r, 0);
    rd(2'd3, r); chk(r == 0, "R6 result reset", r, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {30'd0, scl_oe, sda_oe}, 0);
    rd(2'd1, r); chk(r == 32'h007D_00FA, "R2 timing reset", r, 32'h007D_00FA);

    // R1 commands ignored while halted
    wr(2'd2, cword(1, 0, 1, 8'hA0));
    repeat (60) @(negedge clk);
    chk(irqs == 0 && starts == 0 && !scl_oe, "R1 halted ignores cmd", irqs, 0);

    // R2 program timing: low 3, high 4
    wr(2'd1, {16'd3, 16'd7});
    rd(2'd1, r); chk(r == {16'd3, 16'd7}, "R2 timing readback", r, {16'd3, 16'd7});
    wr(2'd0, 32'd3);

    // R3 address write with ACK
    cmd(1, 0, 1, 8'hA0, 9'b0_0000_0001, "R3 addr");
    rd(2'd3, r); e = expect_res(1, 8'hA0, 1, 9'd1);
    chk(r == e, "R6 addr result", r, e);
    chk(starts == 1, "R3 start seen", starts, 1);
    repeat (10) @(negedge clk);
    chk(last_low == 3 && last_high == 4, "R2 scl low/high", {last_low[15:0], last_high[15:0]}, {16'd3, 16'd4});
    chk(scl_oe == 1'b1, "R11 scl held low", {31'd0, scl_oe}, 1);

    // R4 R5 random write bytes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      logic [8:0] p;
      d = 8'($urandom);
      p = {8'd0, 1'($urandom)};
      cmd(0, 0, 1, d, p, "R4 wr");
      rd(2'd3, r); e = expect_res(1, d, 1, p);
      chk(r == e, "R4/R5 write byte", r, e);
    end

    // R10 command during a byte is ignored
    pat = 9'd1; slv_pull = 1'b0; rises = 0;
    c0 = irqs;
    wr(2'd2, cword(0, 0, 1, 8'h5A));
    repeat (5) @(negedge clk);
    wr(2'd2, cword(1, 0, 1, 8'h0F));
    while (!irq) @(negedge clk);
    rd(2'd3, r); e = expect_res(1, 8'h5A, 1, 9'd1);
    chk(r == e, "R10 busy write ignored", r, e);
    repeat (80) @(negedge clk);
    chk(irqs == c0 + 1, "R10 single irq", irqs, c0 + 1);

    // R3 repeated start, then R4/R5 reads
    c0 = starts;
    cmd(1, 0, 1, 8'hA1, 9'd1, "R3 rstart");
    chk(starts == c0 + 1, "R3 repeated start", starts, c0 + 1);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic n;
      d = 8'($urandom);
      n = (i == 5);
      cmd(0, 0, n, 8'h00, {~d, 1'b0}, "R4 rd");
      rd(2'd3, r); e = expect_res(0, 8'h00, n, {~d, 1'b0});
      chk(r == e, "R4/R5 read byte", r, e);
    end

    // R8 stop
    c0 = stops;
    cmd(0, 1, 1, 8'h00, 9'd0, "R8 stop");
    rd(2'd3, r); chk(r[12] == 1'b0, "R8 bus released flag", r, 0);
    chk(stops == c0 + 1, "R8 stop seen", stops, c0 + 1);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R8 lines released", {30'd0, scl_oe, sda_oe}, 0);

    // R10 command written in the irq cycle is accepted
    cmd(1, 0, 1, 8'hA0, 9'd1, "R10 addr");
    cmd(0, 0, 1, 8'h3C, 9'd1, "R10 irq-cycle cmd");
    rd(2'd3, r); e = expect_res(1, 8'h3C, 1, 9'd1);
    chk(r == e, "R10 irq-cycle result", r, e);

    // R7 arbitration lost in cell 2 of address
    c0 = stops;
    cmd(1, 0, 1, 8'hFE, 9'b0_0100_0000, "R7 lost");
    rd(2'd3, r);
    chk((r & 32'h1200) == 32'h0200, "R7 lost flag", r & 32'h1200, 32'h0200);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R7 lines released", {30'd0, scl_oe, sda_oe}, 0);
    repeat (40) @(negedge clk);
    chk(stops == c0, "R7 no stop", stops, c0);

    // R1 drive disabled: byte runs, lines never pulled
    wr(2'd0, 32'd1);
    oe_seen = 1'b0;
    cmd(1, 0, 1, 8'h00, 9'd0, "R1 nodrive");
    rd(2'd3, r);
    chk(!oe_seen, "R1 no drive", {31'd0, oe_seen}, 0);
    chk(r == 32'h0000_18FF, "R1 nodrive result", r, 32'h0000_18FF);
    cmd(0, 1, 1, 8'h00, 9'd0, "R1 nodrive stop");

    chk(!wide, "R9 irq one cycle", {31'd0, wide}, 0);
    summary();
    $finish;
  end
endmodule